// File: doc/BRIEF.md
# Synchronized-Gate Reciprocal Frequency Counter

This block measures the frequency of a conditioned digital input with the same relative precision at every frequency. Two counters run side by side. One counts rising edges of the measured input and the other counts cycles of a fast reference clock, nominally 30 MHz. A preset gate request from outside sets the rough length of a measurement. The counting window itself opens and closes only on rising edges of the measured input, so it always spans a whole number of input periods.

The measured-edge count therefore has no plus-or-minus-one error. Only the reference count can be off, by at most one pulse, so the relative error is bounded by one over the reference count. When the window closes, the block raises a one-cycle done strobe and holds both counts. Logic outside the block turns the counts into a frequency or a period, as frequency = f_ref × edge_count / ref_count.

If the gate request drops before any input edge has opened a window, the measurement is dropped and a no-signal flag is raised instead.

Top module: `recip_freq_counter`

## Requirements
- R1: While `rst_n` is low, `ref_count` and `meas_count` are 0, and `done` and `no_signal` are low.
- R2: The window opens on the first recognized input rise that finds the block armed with `gate_req` still high. The block becomes armed at the edge after the one where it first sees `gate_req` high while idle. An input rise first captured at clock edge n is recognized at edge n+2. Both counters clear to 0 at the opening edge.
- R3: Once `gate_req` has been seen low with the window open, the window closes at the next recognized input rise. A rise recognized at that same edge does not close it. `done` is high for the clock cycle that follows the closing edge.
- R4: After a close, `meas_count` equals the number of recognized input rises after the opening edge, up to and including the closing edge.
- R5: After a close, `ref_count` equals the number of reference clock edges from the opening edge to the closing edge.
- R6: Each completed window gives exactly one `done` pulse, one cycle long.
- R7: `ref_count` and `meas_count` stay unchanged from a close, or from an abandoned attempt, until the next window opens.
- R8: If `gate_req` is seen low while armed and before any opening rise, no window opens, no `done` is given, the counts keep their old values, and `no_signal` goes high at that edge. `no_signal` returns low when a later window opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference (fill) clock, also the block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_in | input | 1 | Conditioned measured signal, asynchronous to `clk` |
| gate_req | input | 1 | Preset gate request, synchronous to `clk` |
| ref_count | output | CNT_W | Reference cycles inside the last window |
| meas_count | output | CNT_W | Measured-input rises inside the last window |
| done | output | 1 | One-cycle strobe after a window closes |
| no_signal | output | 1 | Set when a gate elapsed without an opening edge |

## Verification
A change on `meas_in` first sampled at edge n affects the window logic at edge n+2. A `gate_req` change takes effect at the edge that samples it. `done`, the counts and `no_signal` are all registered, so they change right after the acting edge. The bench keeps a cycle count and records the edge at which each input rise it drives will be recognized. From those records it computes the exact edges of opening and closing, and from them the cycle `done` is due and the expected counts. It samples the outputs on the falling clock edge, counts `done` pulses over a window longer than the longest possible close delay, and compares the cycle of the pulse with the predicted edge.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

    typedef enum logic [1:0] {
        WIN_IDLE  = 2'd0,
        WIN_ARMED = 2'd1,
        WIN_OPEN  = 2'd2,
        WIN_DRAIN = 2'd3
    } win_state_e;

    typedef struct packed {
        win_state_e st;
        logic       done;
        logic       nosig;
    } win_regs_t;

endpackage

// File: rtl/rfc_edge_sync.sv
module rfc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);
    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_q;
    logic [CHAIN-1:0] chain_d;

    always_comb begin
        chain_d = {chain_q[CHAIN-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

    // A rise pulse lasts one cycle, so each input edge is counted once (R4)
    p_rise_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/rfc_window_ctrl.sv
module rfc_window_ctrl
    import rfc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gate,
    input  logic rise,
    output logic open_o,
    output logic run_o,
    output logic done_o,
    output logic nosig_o
);
    win_regs_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        open_o = 1'b0;
        unique case (q.st)
            WIN_IDLE: begin
                if (gate) d.st = WIN_ARMED;
            end
            WIN_ARMED: begin
                if (!gate) begin
                    d.st    = WIN_IDLE;
                    d.nosig = 1'b1;
                end else if (rise) begin
                    d.st    = WIN_OPEN;
                    d.nosig = 1'b0;
                    open_o  = 1'b1;
                end
            end
            WIN_OPEN: begin
                if (!gate) d.st = WIN_DRAIN;
            end
            WIN_DRAIN: begin
                if (rise) begin
                    d.st   = WIN_IDLE;
                    d.done = 1'b1;
                end
            end
            default: d.st = WIN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: WIN_IDLE, done: 1'b0, nosig: 1'b0};
        else        q <= d;
    end

    assign run_o   = (q.st == WIN_OPEN) || (q.st == WIN_DRAIN);
    assign done_o  = q.done;
    assign nosig_o = q.nosig;

    p_open_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        open_o |-> (gate && rise));

    p_close_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(rise));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_abort_no_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nosig_o) |-> (!done_o && $past(!gate)));

endmodule

// File: rtl/rfc_count_pair.sv
module rfc_count_pair #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         run,
    input  logic         tick,
    output logic [W-1:0] ref_cnt,
    output logic [W-1:0] meas_cnt
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] ref_d, ref_q;
    logic [W-1:0] meas_d, meas_q;

    always_comb begin
        ref_d  = ref_q;
        meas_d = meas_q;
        if (clr) begin
            ref_d  = '0;
            meas_d = '0;
        end else if (run) begin
            ref_d  = ref_q + ONE;
            if (tick) meas_d = meas_q + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q  <= '0;
            meas_q <= '0;
        end else begin
            ref_q  <= ref_d;
            meas_q <= meas_d;
        end
    end

    assign ref_cnt  = ref_q;
    assign meas_cnt = meas_q;

    p_ref_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr) |=> (ref_cnt == $past(ref_cnt) + ONE));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> ($stable(ref_cnt) && $stable(meas_cnt)));

endmodule

// File: rtl/recip_freq_counter.sv
module recip_freq_counter #(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             meas_in,
    input  logic             gate_req,
    output logic [CNT_W-1:0] ref_count,
    output logic [CNT_W-1:0] meas_count,
    output logic             done,
    output logic             no_signal
);
    logic rise;
    logic open_w;
    logic run_w;

    rfc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (meas_in),
        .rise_o   (rise)
    );

    rfc_window_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .gate    (gate_req),
        .rise    (rise),
        .open_o  (open_w),
        .run_o   (run_w),
        .done_o  (done),
        .nosig_o (no_signal)
    );

    rfc_count_pair #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (open_w),
        .run      (run_w),
        .tick     (rise),
        .ref_cnt  (ref_count),
        .meas_cnt (meas_count)
    );

    p_meas_le_ref_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (meas_count <= ref_count));

endmodule

// File: tb/recip_freq_counter_bench.sv
module recip_freq_counter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MAXR = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        meas_in = 1'b0;
    logic        gate_req = 1'b0;
    logic [31:0] ref_count, meas_count;
    logic        done, no_signal;

    recip_freq_counter u_recip_freq_counter (
        .clk(clk), .rst_n(rst_n), .meas_in(meas_in), .gate_req(gate_req),
        .ref_count(ref_count), .meas_count(meas_count),
        .done(done), .no_signal(no_signal)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 0;
    int rise_act [0:MAXR-1];
    int nrise = 0;
    int gen_p = 4, gen_hi = 2, gen_ph = 0;
    bit gen_on = 0;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // advance to the next falling edge and drive the input generator
    task automatic step();
        logic nv;
        @(negedge clk);
        if (gen_on) begin
            gen_ph = (gen_ph + 1) % gen_p;
            nv = (gen_ph < gen_hi);
            if (nv && !meas_in && nrise < MAXR) begin
                rise_act[nrise] = cyc + 3;   // sampled at cyc+1, recognized two edges later
                nrise++;
            end
            meas_in = nv;
        end
    endtask

    function automatic int first_open(int g0, int gl);
        for (int i = 0; i < nrise; i++)
            if (rise_act[i] >= g0 + 1 && rise_act[i] <= gl - 1) return rise_act[i];
        return -1;
    endfunction

    function automatic int first_close(int gl);
        for (int i = 0; i < nrise; i++)
            if (rise_act[i] > gl) return rise_act[i];
        return -1;
    endfunction

    function automatic int rises_between(int a, int c);
        int n = 0;
        for (int i = 0; i < nrise; i++)
            if (rise_act[i] > a && rise_act[i] <= c) n++;
        return n;
    endfunction

    task automatic run_case(int p, int glen, bit on);
        int g0, gl, a, c, n_done, done_cyc, warm;
        logic [31:0] prev_ref, prev_meas, hold_ref, hold_meas;
        gen_p = p; gen_hi = p / 2; gen_on = on; nrise = 0;
        warm = $urandom_range(0, p);
        repeat (warm + 1) step();
        prev_ref = ref_count; prev_meas = meas_count;
        gate_req = 1'b1; g0 = cyc + 1;
        repeat (glen) step();
        gate_req = 1'b0; gl = cyc + 1;
        n_done = 0; done_cyc = -1;
        for (int k = 0; k < 2 * p + 12; k++) begin
            step();
            if (done) begin
                n_done++;
                if (done_cyc < 0) done_cyc = cyc;
            end
        end
        a = first_open(g0, gl);
        if (a >= 0) begin
            c = first_close(gl);
            chk(n_done == 1, "R6", "done pulse count", n_done, 1);
            chk(done_cyc == c, "R3", "done cycle", done_cyc, c);
            chk(ref_count == 32'(c - a), "R2 R5", "ref_count", ref_count, c - a);
            chk(meas_count == 32'(rises_between(a, c)), "R4", "meas_count",
                meas_count, rises_between(a, c));
            chk(no_signal == 1'b0, "R8", "no_signal after good window", no_signal, 0);
            hold_ref = ref_count; hold_meas = meas_count;
            repeat (4) step();
            chk(ref_count == hold_ref && meas_count == hold_meas, "R7",
                "counts held after close", ref_count, hold_ref);
        end else begin
            chk(n_done == 0, "R8", "done pulses on abort", n_done, 0);
            chk(no_signal == 1'b1, "R8", "no_signal on abort", no_signal, 1);
            chk(ref_count == prev_ref && meas_count == prev_meas, "R7",
                "counts kept on abort", meas_count, prev_meas);
        end
        repeat (3) step();
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(ref_count == 0, "R1", "ref_count in reset", ref_count, 0);
        chk(meas_count == 0, "R1", "meas_count in reset", meas_count, 0);
        chk(done == 0, "R1", "done in reset", done, 0);
        chk(no_signal == 0, "R1", "no_signal in reset", no_signal, 0);
        rst_n = 1'b1;
        repeat (2) step();
        // directed corners
        run_case(2, 20, 1'b1);     // fastest input
        run_case(3, 1, 1'b1);      // shortest gate
        run_case(5, 40, 1'b0);     // no input at all: abandon
        run_case(6, 60, 1'b1);     // no_signal must clear
        run_case(40, 5, 1'b1);     // slow input, short gate
        run_case(30, 200, 1'b1);   // long window
        for (int t = 0; t < 30; t++)
            run_case($urandom_range(2, 30), $urandom_range(1, 250),
                     ($urandom_range(0, 7) != 0));
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL R3 watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule